// File: doc/BRIEF.md
# Hybrid frequency/duty gate modulator for a resonant half bridge

This block drives the two switches of a half-bridge resonant converter, plus an auxiliary front-end switch. It takes a stream of output-voltage samples and a static reference code. A proportional-integral loop turns the error between them into a switching period for an internal sawtooth counter, and the period is clamped between a lower and an upper limit. While the period sits strictly inside those limits, the compare threshold is half the period. Regulation then comes from frequency alone, at exactly 50 % duty. When the period reaches a limit, a separate trim accumulator moves the threshold. The direction of that move depends on which limit was reached.

The low-side gate conducts during the first part of each sawtooth period and the high-side gate conducts during the rest. An auxiliary output always mirrors the low-side gate. A programmable number of dead clocks is placed at every hand-over between the two gates. A two-bit signed flag reports which period limit is active, and a mode pin shows whether the duty is currently free to move.

Samples arrive on a valid/ready stream. The intake holds no queue. After each accepted sample, `fb_ready` stays low for exactly one clock while the loop arithmetic updates. A producer that keeps `fb_valid` high must hold `fb_data` until it sees `fb_ready` high at a rising edge. `ref_code` and `dead_time` are plain control inputs.

Top module: `pfm_pwm_modulator`

## Requirements
- R1: `fb_ready` is low while `rst_n` is low. Out of reset it is high when idle. After every clock edge where `fb_valid && fb_ready`, it is low for exactly one cycle and then high again, so a held-valid producer gets one sample accepted every two clocks.
- R2: An accepted sample gives err = fb_data − ref_code. On the next edge the integrator becomes I = clamp(I + KI·err, 0, 947), with KI = 1 and a reset value of 473. The period command becomes P = clamp(2000 − (I + KP·err), 1053, 2000), with KP = 2 and a reset value of 1527. Without an accepted sample, both values hold.
- R3: The sawtooth counts 0 to P−1. A new period command and a new threshold are loaded only on the edge where the count wraps from P−1 to 0. A period in progress keeps the length it started with.
- R4: `lim_flag` follows the active period: 2'b01 (+1) at 2000 (lowest frequency), 2'b11 (−1) at 1053 (highest frequency), and 2'b00 otherwise. `pwm_mode` is 1 exactly when `lim_flag` is not 2'b00.
- R5: If the active period is strictly between the limits, the threshold is P>>1. The raw low-side phase is active while count < threshold, and with zero dead time `gate_lo` follows it one clock later. The period 1527 therefore gives 763 low-side clocks out of 1527.
- R6: The trim T (reset value 0) is updated together with P as T − KT·err, with KT = 1. It is clamped to [0, 255] when the new P is 2000 and to [−255, 0] when the new P is 1053, and it is forced to 0 otherwise. The low-side duty can therefore only rise at the low-frequency limit and only fall at the high-frequency limit.
- R7: At a period load the threshold is (P>>1) + clamp(T, −M, M), where M = (P·51)>>9. This keeps duty within roughly 0.4 to 0.6: threshold 1199 at P = 2000 with T = 255, and threshold 422 at P = 1053 with T = −255.
- R8: `gate_hi` and `gate_lo` are never high together. Whenever the raw phase changes, both are low for `dead_time` clocks, using the `dead_time` value present at that edge. Then the new side turns on. The rise-to-rise spacing of `gate_lo` stays one period.
- R9: `gate_aux` equals `gate_lo` in every cycle.
- R10: While `rst_n` is low, all three gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock (100 MHz in the target design) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_code | input | 12 | Target output-voltage code |
| fb_valid | input | 1 | Feedback sample valid |
| fb_ready | output | 1 | Feedback sample accepted on this edge when high with valid |
| fb_data | input | 12 | Measured output-voltage code |
| dead_time | input | 6 | Dead clocks at each gate hand-over |
| gate_hi | output | 1 | High-side switch drive |
| gate_lo | output | 1 | Low-side switch drive |
| gate_aux | output | 1 | Auxiliary front-end switch drive, same as gate_lo |
| lim_flag | output | 2 | Period-limit flag: 01 = +1, 11 = −1, 00 = 0 |
| pwm_mode | output | 1 | High while the period is pinned at a limit |

## Verification
The assertions check every cycle that the intake drops ready after a handshake, that commands hold between updates, and that period and threshold change only at the wrap. They also check that the threshold is exactly half the period when the period is unsaturated, and that at each limit it sits on the correct side of half and inside the duty window. Shoot-through, the dead band and gates-off-in-reset are also checked on every cycle. The actual loop arithmetic, the clamped period and threshold values, the measured on-time and dead-band length, and the throughput of one sample per two clocks under held valid can be shown only by the bench's scenarios. The bench compares these against its behavioural model and against measured pulse widths.

// File: rtl/pfm_pwm_pkg.sv
package pfm_pwm_pkg;

  localparam logic [1:0] LIM_NONE = 2'b00;
  localparam logic [1:0] LIM_SLOW = 2'b01;
  localparam logic [1:0] LIM_FAST = 2'b11;

  function automatic longint clip(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // threshold: half period plus a trim bounded to about a tenth of the period
  function automatic longint duty_thr(longint per, longint trim);
    longint m;
    m = (per * 51) >>> 9;
    return (per >>> 1) + clip(trim, -m, m);
  endfunction

endpackage

// File: rtl/pfm_pwm_pi.sv
module pfm_pwm_pi
  import pfm_pwm_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int PER_MIN  = 1053,
  parameter int PER_MAX  = 2000,
  parameter int KP       = 2,
  parameter int KI       = 1,
  parameter int KT       = 1,
  parameter int TRIM_LIM = 255,
  parameter int PER_W    = 11,
  parameter int TRIM_W   = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        ref_code,
  input  logic                     fb_valid,
  output logic                     fb_ready,
  input  logic [DATA_W-1:0]        fb_data,
  output logic [PER_W-1:0]         per_cmd,
  output logic signed [TRIM_W-1:0] trim_cmd
);

  localparam int SPAN    = PER_MAX - PER_MIN;
  localparam int INT_RST = SPAN / 2;
  localparam int PER_RST = PER_MAX - INT_RST;

  logic                     busy;
  logic                     take;
  logic signed [DATA_W:0]   err_q;
  logic [PER_W-1:0]         integ;
  longint                   e_l, integ_n, ctl_l, per_n, trim_n;

  assign fb_ready = rst_n & ~busy;
  assign take     = fb_valid & fb_ready;

  // stage 1: capture the error of an accepted sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      err_q <= '0;
    end else begin
      busy <= take;
      if (take) err_q <= $signed({1'b0, fb_data}) - $signed({1'b0, ref_code});
    end
  end

  // stage 2 arithmetic: integrator, proportional term, period clamp, trim
  always_comb begin
    e_l     = longint'(err_q);
    integ_n = clip(longint'(integ) + longint'(KI) * e_l, 0, longint'(SPAN));
    ctl_l   = integ_n + longint'(KP) * e_l;
    per_n   = clip(longint'(PER_MAX) - ctl_l, longint'(PER_MIN), longint'(PER_MAX));
    trim_n  = longint'(trim_cmd) - longint'(KT) * e_l;
    if (per_n == longint'(PER_MAX))
      trim_n = clip(trim_n, 0, longint'(TRIM_LIM));
    else if (per_n == longint'(PER_MIN))
      trim_n = clip(trim_n, -longint'(TRIM_LIM), 0);
    else
      trim_n = 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ    <= PER_W'(INT_RST);
      per_cmd  <= PER_W'(PER_RST);
      trim_cmd <= '0;
    end else if (busy) begin
      integ    <= PER_W'(integ_n);
      per_cmd  <= PER_W'(per_n);
      trim_cmd <= TRIM_W'(trim_n);
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !fb_ready) else $error("ready stayed high after handshake"); // R1

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(per_cmd) && $stable(trim_cmd))) else $error("command moved without sample"); // R2

endmodule

// File: rtl/pfm_pwm_saw.sv
module pfm_pwm_saw
  import pfm_pwm_pkg::*;
#(
  parameter int PER_MIN = 1053,
  parameter int PER_MAX = 2000,
  parameter int PER_W   = 11,
  parameter int TRIM_W  = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PER_W-1:0]         per_cmd,
  input  logic signed [TRIM_W-1:0] trim_cmd,
  output logic                     raw_lo,
  output logic [1:0]               lim_flag,
  output logic                     pwm_mode
);

  localparam int PER_RST = PER_MAX - (PER_MAX - PER_MIN) / 2;
  localparam int THR_RST = PER_RST / 2;

  logic [PER_W-1:0] cnt, per_act, thr_act, thr_n;
  logic             wrap;

  assign wrap = (cnt == per_act - 1'b1);

  always_comb thr_n = PER_W'(duty_thr(longint'(per_cmd), longint'(trim_cmd)));

  // period and threshold are swapped in only at the wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_act <= PER_W'(PER_RST);
      thr_act <= PER_W'(THR_RST);
    end else if (wrap) begin
      cnt     <= '0;
      per_act <= per_cmd;
      thr_act <= thr_n;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign raw_lo = (cnt < thr_act);

  always_comb begin
    if (per_act == PER_W'(PER_MAX))      lim_flag = LIM_SLOW;
    else if (per_act == PER_W'(PER_MIN)) lim_flag = LIM_FAST;
    else                                 lim_flag = LIM_NONE;
  end
  assign pwm_mode = (lim_flag != LIM_NONE);

  logic [PER_W-1:0] half_act, mrg_act;
  assign half_act = per_act >> 1;
  assign mrg_act  = PER_W'((32'(per_act) * 32'd51) >> 9);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per_act) else $error("count beyond period"); // R3

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(per_act) && $stable(thr_act))) else $error("mid-period change"); // R3

  AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (per_act == $past(per_cmd))) else $error("period not loaded at wrap"); // R3

  AST_PFM_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_flag == LIM_NONE) |-> (thr_act == half_act)) else $error("duty not half"); // R5

  AST_SLOW_WIDENS: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_flag == LIM_SLOW) |-> (thr_act >= half_act)) else $error("duty fell at slow limit"); // R6

  AST_FAST_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_flag == LIM_FAST) |-> (thr_act <= half_act)) else $error("duty rose at fast limit"); // R6

  AST_DUTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr_act + mrg_act >= half_act) && (thr_act <= half_act + mrg_act))) else $error("duty out of window"); // R7

endmodule

// File: rtl/pfm_pwm_deadband.sv
module pfm_pwm_deadband #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_lo,
  input  logic [DT_W-1:0] dead_time,
  output logic            gate_hi,
  output logic            gate_lo
);

  logic            side;
  logic [DT_W-1:0] dcnt;
  logic            quiet;
  logic [1:0]      leg;

  assign quiet = (dcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side <= 1'b1;
      dcnt <= '0;
    end else if (raw_lo != side) begin
      side <= raw_lo;
      dcnt <= dead_time;
    end else if (!quiet) begin
      dcnt <= dcnt - 1'b1;
    end
  end

  // leg 0 drives the low side, leg 1 the high side
  for (genvar gi = 0; gi < 2; gi++) begin : g_leg
    localparam bit ON_LO = (gi == 0);
    assign leg[gi] = rst_n & quiet & (side == ON_LO);
  end

  assign gate_lo = leg[0];
  assign gate_hi = leg[1];

  always_comb begin
    AST_NO_SHOOT_THROUGH: assert (!(gate_hi && gate_lo)) else $error("both gates on"); // R8
    if (!rst_n) begin
      AST_OFF_IN_RESET: assert (!gate_hi && !gate_lo) else $error("gate on in reset"); // R10
    end
  end

  AST_DEAD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_lo != side) && (dead_time != '0)) |=> (!gate_hi && !gate_lo)) else $error("no dead band"); // R8

endmodule

// File: rtl/pfm_pwm_modulator.sv
module pfm_pwm_modulator #(
  parameter int DATA_W   = 12,
  parameter int PER_MIN  = 1053,
  parameter int PER_MAX  = 2000,
  parameter int KP       = 2,
  parameter int KI       = 1,
  parameter int KT       = 1,
  parameter int TRIM_LIM = 255,
  parameter int DT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ref_code,
  input  logic              fb_valid,
  output logic              fb_ready,
  input  logic [DATA_W-1:0] fb_data,
  input  logic [DT_W-1:0]   dead_time,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic              gate_aux,
  output logic [1:0]        lim_flag,
  output logic              pwm_mode
);

  localparam int PER_W  = $clog2(PER_MAX + 1);
  localparam int TRIM_W = $clog2(TRIM_LIM + 1) + 1;

  logic [PER_W-1:0]         per_cmd;
  logic signed [TRIM_W-1:0] trim_cmd;
  logic                     raw_lo;

  pfm_pwm_pi #(
    .DATA_W(DATA_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .KP(KP), .KI(KI),
    .KT(KT), .TRIM_LIM(TRIM_LIM), .PER_W(PER_W), .TRIM_W(TRIM_W)
  ) u_pi (
    .clk(clk), .rst_n(rst_n), .ref_code(ref_code), .fb_valid(fb_valid),
    .fb_ready(fb_ready), .fb_data(fb_data), .per_cmd(per_cmd), .trim_cmd(trim_cmd)
  );

  pfm_pwm_saw #(
    .PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .PER_W(PER_W), .TRIM_W(TRIM_W)
  ) u_saw (
    .clk(clk), .rst_n(rst_n), .per_cmd(per_cmd), .trim_cmd(trim_cmd),
    .raw_lo(raw_lo), .lim_flag(lim_flag), .pwm_mode(pwm_mode)
  );

  pfm_pwm_deadband #(.DT_W(DT_W)) u_db (
    .clk(clk), .rst_n(rst_n), .raw_lo(raw_lo), .dead_time(dead_time),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  assign gate_aux = gate_lo;

endmodule

// File: tb/pfm_pwm_modulator_bench.sv
module pfm_pwm_modulator_bench;

  localparam int PMIN = 1053;
  localparam int PMAX = 2000;
  localparam int SPAN = PMAX - PMIN;
  localparam int TLIM = 255;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [11:0] ref_code, fb_data;
  logic       fb_valid, fb_ready;
  logic [5:0] dead_time;
  logic       gate_hi, gate_lo, gate_aux, pwm_mode;
  logic [1:0] lim_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pfm_pwm_modulator u_pfm_pwm_modulator (
    .clk(clk), .rst_n(rst_n), .ref_code(ref_code), .fb_valid(fb_valid),
    .fb_ready(fb_ready), .fb_data(fb_data), .dead_time(dead_time),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .gate_aux(gate_aux),
    .lim_flag(lim_flag), .pwm_mode(pwm_mode)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int thr_of(int p, int t);
    int m;
    m = (p * 51) / 512;
    return p / 2 + lim(t, -m, m);
  endfunction

  // behavioural reference model
  int m_busy, m_err, m_integ, m_pcmd, m_trim, m_cnt, m_pact, m_thr, m_side, m_dcnt;
  int n_raw, n_take, n_e, n_i, n_p, n_t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_integ = SPAN / 2; m_pcmd = PMAX - SPAN / 2; m_trim = 0;
      m_cnt = 0; m_pact = PMAX - SPAN / 2; m_thr = (PMAX - SPAN / 2) / 2;
      m_side = 1; m_dcnt = 0;
    end else begin
      n_raw  = (m_cnt < m_thr) ? 1 : 0;
      n_take = (fb_valid && m_busy == 0) ? 1 : 0;
      n_i = m_integ; n_p = m_pcmd; n_t = m_trim;
      if (m_busy != 0) begin
        n_e = m_err;
        n_i = lim(m_integ + n_e, 0, SPAN);
        n_p = lim(PMAX - (n_i + 2 * n_e), PMIN, PMAX);
        n_t = m_trim - n_e;
        if (n_p == PMAX) n_t = lim(n_t, 0, TLIM);
        else if (n_p == PMIN) n_t = lim(n_t, -TLIM, 0);
        else n_t = 0;
      end
      if (m_cnt == m_pact - 1) begin
        m_cnt = 0; m_pact = m_pcmd; m_thr = thr_of(m_pcmd, m_trim);
      end else m_cnt++;
      m_integ = n_i; m_pcmd = n_p; m_trim = n_t;
      if (n_raw != m_side) begin m_side = n_raw; m_dcnt = int'(dead_time); end
      else if (m_dcnt > 0) m_dcnt--;
      if (n_take != 0) m_err = int'(fb_data) - int'(ref_code);
      m_busy = n_take;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      automatic int e_lo = (rst_n && m_side == 1 && m_dcnt == 0) ? 1 : 0;
      automatic int e_hi = (rst_n && m_side == 0 && m_dcnt == 0) ? 1 : 0;
      automatic int e_fl = (m_pact == PMAX) ? 1 : ((m_pact == PMIN) ? 3 : 0);
      automatic int e_rd = (rst_n && m_busy == 0) ? 1 : 0;
      chk(int'(gate_lo) == e_lo, "R8/R10 gate_lo vs model", int'(gate_lo), e_lo);
      chk(int'(gate_hi) == e_hi, "R8/R10 gate_hi vs model", int'(gate_hi), e_hi);
      chk(gate_aux == gate_lo, "R9 gate_aux mirrors gate_lo", int'(gate_aux), int'(gate_lo));
      chk(int'(lim_flag) == e_fl, "R4 lim_flag vs model", int'(lim_flag), e_fl);
      chk(int'(pwm_mode) == (e_fl != 0 ? 1 : 0), "R4 pwm_mode vs model", int'(pwm_mode), (e_fl != 0 ? 1 : 0));
      chk(int'(fb_ready) == e_rd, "R1 fb_ready vs model", int'(fb_ready), e_rd);
    end
  end

  task automatic wait_rise();
    bit p;
    p = gate_lo;
    forever begin
      @(negedge clk);
      if (gate_lo && !p) break;
      p = gate_lo;
    end
  endtask

  task automatic settle();
    wait_rise();
    wait_rise();
  endtask

  // called at a gate_lo rise; counts until the next rise, optionally injecting two samples
  task automatic measure(input int inj, input int d1, input int d2, output int per, output int on);
    bit p;
    p = gate_lo; per = 1; on = int'(gate_lo);
    forever begin
      @(negedge clk);
      if (gate_lo && !p) break;
      on += int'(gate_lo); per++; p = gate_lo;
      if (inj > 0) begin
        if (per == inj)     begin fb_valid = 1'b1; fb_data = 12'(d1); end
        if (per == inj + 1) fb_valid = 1'b0;
        if (per == inj + 3) begin fb_valid = 1'b1; fb_data = 12'(d2); end
        if (per == inj + 4) fb_valid = 1'b0;
      end
    end
  endtask

  task automatic send(input int d);
    fb_data = 12'(d);
    fb_valid = 1'b1;
    while (!fb_ready) @(negedge clk);
    @(negedge clk);
    fb_valid = 1'b0;
  endtask

  initial begin
    int p, on, acc, g;
    bit q;
    rst_n = 1'b0; fb_valid = 1'b0; fb_data = 12'd2000; ref_code = 12'd2000; dead_time = 6'd0;
    repeat (3) @(negedge clk);
    chk(!gate_hi && !gate_lo && !gate_aux, "R10 gates off during reset", int'(gate_hi | gate_lo | gate_aux), 0);
    chk(!fb_ready, "R1 ready low during reset", int'(fb_ready), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(lim_flag == 2'b00 && !pwm_mode, "R4 flag zero after reset", int'(lim_flag), 0);

    wait_rise();
    measure(0, 0, 0, p, on);
    chk(p == 1527, "R2 reset period", p, 1527);
    chk(on == 763, "R5 half duty at reset period", on, 763);

    send(2000);
    settle(); measure(0, 0, 0, p, on);
    chk(p == 1527, "R2 zero error keeps period", p, 1527);

    send(1500);
    settle(); measure(0, 0, 0, p, on);
    chk(p == PMAX, "R2 period clamped at upper limit", p, PMAX);
    chk(on == thr_of(PMAX, TLIM), "R7 threshold window at slow limit", on, thr_of(PMAX, TLIM));
    chk(on > p / 2, "R6 low-side duty above half at slow limit", on, p / 2 + 1);
    chk(lim_flag == 2'b01 && pwm_mode, "R4 flag +1 at slow limit", int'(lim_flag), 1);

    measure(10, 2473, 2000, p, on);
    chk(p == PMAX, "R3 period in progress keeps its length", p, PMAX);
    chk(on == 1199, "R3 threshold in progress kept", on, 1199);
    measure(0, 0, 0, p, on);
    chk(p == 1527, "R3 new period from the wrap", p, 1527);
    chk(on == 763, "R6 trim cleared when unsaturated", on, 763);
    chk(lim_flag == 2'b00 && !pwm_mode, "R4 flag zero in frequency region", int'(lim_flag), 0);

    send(2600);
    settle(); measure(0, 0, 0, p, on);
    chk(p == PMIN, "R2 period clamped at lower limit", p, PMIN);
    chk(on == 422, "R7 threshold window at fast limit", on, 422);
    chk(on < p / 2, "R6 low-side duty below half at fast limit", on, p / 2 - 1);
    chk(lim_flag == 2'b11 && pwm_mode, "R4 flag -1 at fast limit", int'(lim_flag), 3);

    @(negedge clk) dead_time = 6'd5;
    settle(); measure(0, 0, 0, p, on);
    chk(p == PMIN, "R8 rise spacing unchanged with dead time", p, PMIN);
    chk(on == 417, "R8 dead time removed from low-side pulse", on, 417);
    q = gate_lo;
    forever begin
      @(negedge clk);
      if (!gate_lo && q) break;
      q = gate_lo;
    end
    g = 0;
    while (!gate_hi) begin g++; @(negedge clk); end
    chk(g == 5, "R8 dead band length", g, 5);
    chk(gate_aux == gate_lo, "R9 aux equals low side", int'(gate_aux), int'(gate_lo));

    @(negedge clk);
    fb_data = 12'd2000; fb_valid = 1'b1; acc = 0;
    for (int k = 0; k < 20; k++) begin
      if (fb_ready) acc++;
      @(negedge clk);
    end
    fb_valid = 1'b0;
    chk(acc == 10, "R1 one accept per two clocks under held valid", acc, 10);
    settle(); measure(0, 0, 0, p, on);
    chk(p == PMIN && on == 417, "R2 zero error holds fast limit", p, PMIN);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule